// File: doc/BRIEF.md
# Four-Lane Half-to-Single Precision Unpacker

This block widens packed binary16 floating-point data to binary32. One input word carries four 16-bit half-precision values. The block returns one output word that carries the four matching 32-bit single-precision values, with the lanes in the same order. Every half value has an exact single-precision form, so the conversion never rounds. The result is bit-exact.

Each lane is decoded on its own and in parallel with the others. The lane's 5-bit exponent field puts it in one of three classes:

- **Zero or subnormal** (exponent field all zeros). A nonzero subnormal is renormalised with a leading-one search, so it becomes a normal single.
- **Normal.** The exponent is rebiased.
- **Infinity or NaN** (exponent field all ones). The single exponent saturates to all ones and the half mantissa is carried over, so a NaN payload survives.

A word is accepted whenever the input valid is high. The converted word appears on registered outputs one clock later. The output data holds its value until the next accepted word.

Top module: `quad_half_unpack`

## Requirements
- R1: Lane i takes input bits [16i+15:16i] and writes output bits [32i+31:32i], with lane 0 in the least significant position; lanes do not affect each other.
- R2: Output bit 31 of each lane equals input bit 15 of that lane for every class, including zero and NaN.
- R3: A lane whose exponent field (half bits 14:10) is neither 0 nor 31 gives single exponent = half exponent + 112, and single mantissa = half mantissa (bits 9:0) followed by 13 zero bits.
- R4: A lane with exponent field 31 and mantissa 0 gives single exponent 255 with mantissa 0 (signed infinity).
- R5: A lane with exponent field 31 and a nonzero mantissa gives single exponent 255, with the half mantissa in single bits 22:13 and zeros in bits 12:0.
- R6: A lane with exponent field 0 and mantissa 0 gives a single whose bits 30:0 are all zero (signed zero).
- R7: A lane with exponent field 0 and a nonzero mantissa m gives the normal single of value m·2^-24. If p is the index of the highest set bit of m, the exponent is 103+p and the mantissa is the remaining lower bits of m, left-aligned.
- R8: `out_valid` is high in exactly the cycle after a cycle with `in_valid` high. `out_data` changes only in the cycle after an accepted word, and otherwise keeps its value.
- R9: While `rst` is high at a clock edge, `out_valid` and `out_data` clear to zero, whatever `in_valid` is.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word is present and accepted this cycle |
| in_data | input | 64 | Four packed half-precision values, lane 0 lowest |
| out_valid | output | 1 | Converted word is present |
| out_data | output | 128 | Four packed single-precision values, lane 0 lowest |

## Verification
One input word can hold all three lane classes at once, so the subnormal, normal and special paths all produce results in the same cycle. The bench builds words whose lanes draw their class at random from zeros, subnormals, normals, infinities and NaNs. It compares every lane against a reference written in a different way from the design: it shifts the subnormal left until it is normalised, instead of searching for the leading one. Accepting a new word also falls in the same cycle as presenting the previous result. Back-to-back words with no gap, mixed with idle gaps, check that each result shows up exactly one cycle later and then holds steady.

// File: rtl/hcvt_pkg.sv
package hcvt_pkg;

   // Half-precision field layout
   localparam int H_W      = 16;
   localparam int H_EXP_W  = 5;
   localparam int H_MAN_W  = 10;
   localparam int H_BIAS   = 15;

   // Single-precision field layout
   localparam int S_W      = 32;
   localparam int S_EXP_W  = 8;
   localparam int S_MAN_W  = 23;
   localparam int S_BIAS   = 127;

   // Derived conversion constants
   localparam int MAN_PAD     = S_MAN_W - H_MAN_W;              // 13
   localparam int REBIAS      = S_BIAS - H_BIAS;                // 112
   localparam int SUB_BASE    = S_BIAS - (H_BIAS - 1) - H_MAN_W; // 103
   localparam int LEAD_IDX_W  = $clog2(H_MAN_W);
   localparam int SHAMT_W     = $clog2(H_MAN_W + 1);

   typedef enum logic [1:0] {
      CLS_ZERO_SUB = 2'd0,
      CLS_NORMAL   = 2'd1,
      CLS_SPECIAL  = 2'd2
   } lane_cls_t;

   typedef struct packed {
      logic               sign;
      logic [H_EXP_W-1:0] exp;
      logic [H_MAN_W-1:0] man;
   } half_t;

   typedef struct packed {
      logic               sign;
      logic [S_EXP_W-1:0] exp;
      logic [S_MAN_W-1:0] man;
   } single_t;

endpackage

// File: rtl/hcvt_lead_one.sv
module hcvt_lead_one #(
   parameter int W     = 10,
   parameter int IDX_W = (W > 1) ? $clog2(W) : 1
) (
   input  logic [W-1:0]     vec,
   output logic [IDX_W-1:0] idx,
   output logic             found
);

   if (W < 2) begin : g_bad_width
      $error("hcvt_lead_one: W must be at least 2");
   end

   // Scan low to high so the highest set bit is the last to win.
   always_comb begin
      idx   = '0;
      found = 1'b0;
      for (int i = 0; i < W; i++) begin
         if (vec[i]) begin
            idx   = IDX_W'(i);
            found = 1'b1;
         end
      end
   end

endmodule

// File: rtl/hcvt_lane.sv
module hcvt_lane
   import hcvt_pkg::*;
(
   input  logic [H_W-1:0] half_in,
   output logic [S_W-1:0] single_out,
   output lane_cls_t      cls
);

   half_t               h;
   single_t             s;
   logic                exp_zero;
   logic                exp_ones;
   logic [LEAD_IDX_W-1:0] lead_idx;
   logic                lead_found;
   logic [SHAMT_W-1:0]  shamt;
   logic [H_MAN_W-1:0]  norm_man;
   logic [S_EXP_W-1:0]  sub_exp;
   logic [S_EXP_W-1:0]  nrm_exp;

   assign h        = half_t'(half_in);
   assign exp_zero = (h.exp == '0);
   assign exp_ones = &h.exp;

   // Class select from the exponent field only
   always_comb begin
      if (exp_ones)      cls = CLS_SPECIAL;
      else if (exp_zero) cls = CLS_ZERO_SUB;
      else               cls = CLS_NORMAL;
   end

   hcvt_lead_one #(
      .W     (H_MAN_W),
      .IDX_W (LEAD_IDX_W)
   ) i_lead (
      .vec   (h.man),
      .idx   (lead_idx),
      .found (lead_found)
   );

   // Subnormal: push the leading one out of the top, it becomes implicit
   assign shamt    = SHAMT_W'(H_MAN_W - int'(lead_idx));
   assign norm_man = h.man << shamt;
   assign sub_exp  = S_EXP_W'(SUB_BASE + int'(lead_idx));
   assign nrm_exp  = S_EXP_W'(int'(h.exp) + REBIAS);

   always_comb begin
      s.sign = h.sign;
      s.exp  = '0;
      s.man  = '0;
      unique case (cls)
         CLS_SPECIAL: begin
            s.exp = '1;
            s.man = {h.man, {MAN_PAD{1'b0}}};
         end
         CLS_NORMAL: begin
            s.exp = nrm_exp;
            s.man = {h.man, {MAN_PAD{1'b0}}};
         end
         default: begin
            if (lead_found) begin
               s.exp = sub_exp;
               s.man = {norm_man, {MAN_PAD{1'b0}}};
            end
         end
      endcase
   end

   assign single_out = S_W'(s);

endmodule

// File: rtl/hcvt_out_reg.sv
module hcvt_out_reg #(
   parameter int W = 128
) (
   input  logic         clk,
   input  logic         rst,
   input  logic         load,
   input  logic [W-1:0] d,
   output logic         valid_q,
   output logic [W-1:0] q
);

   if (W < 1) begin : g_bad_width
      $error("hcvt_out_reg: W must be positive");
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q <= 1'b0;
         q       <= '0;
      end else begin
         valid_q <= load;
         if (load) q <= d;
      end
   end

endmodule

// File: rtl/quad_half_unpack.sv
module quad_half_unpack
   import hcvt_pkg::*;
#(
   parameter int LANES = 4,
   localparam int IN_W  = LANES * H_W,
   localparam int OUT_W = LANES * S_W
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             in_valid,
   input  logic [IN_W-1:0]  in_data,
   output logic             out_valid,
   output logic [OUT_W-1:0] out_data
);

   if (LANES < 1 || LANES > 16) begin : g_bad_lanes
      $error("quad_half_unpack: LANES must be 1..16");
   end

   logic [S_W-1:0] lane_word [LANES];
   lane_cls_t      lane_cls  [LANES];
   logic [OUT_W-1:0] packed_out;

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      hcvt_lane i_lane (
         .half_in    (in_data[H_W*i +: H_W]),
         .single_out (lane_word[i]),
         .cls        (lane_cls[i])
      );
      assign packed_out[S_W*i +: S_W] = lane_word[i];

      // Per-lane checks against the lane's input fields
      assert_sign_R2: assert property (@(posedge clk) disable iff (rst)
         lane_word[i][S_W-1] == in_data[H_W*i + H_W - 1]);

      assert_normal_range_R3: assert property (@(posedge clk) disable iff (rst)
         (in_data[H_W*i + H_MAN_W +: H_EXP_W] != '0 &&
          in_data[H_W*i + H_MAN_W +: H_EXP_W] != '1)
         |-> (lane_word[i][S_MAN_W +: S_EXP_W] > S_EXP_W'(REBIAS) &&
              lane_word[i][S_MAN_W +: S_EXP_W] < S_EXP_W'(REBIAS + 31) &&
              lane_word[i][MAN_PAD-1:0] == '0));

      assert_special_exp_R4: assert property (@(posedge clk) disable iff (rst)
         (in_data[H_W*i + H_MAN_W +: H_EXP_W] == '1)
         |-> (lane_word[i][S_MAN_W +: S_EXP_W] == '1));

      assert_payload_kept_R5: assert property (@(posedge clk) disable iff (rst)
         (in_data[H_W*i + H_MAN_W +: H_EXP_W] == '1)
         |-> (lane_word[i][S_MAN_W-1 -: H_MAN_W] == in_data[H_W*i +: H_MAN_W] &&
              lane_word[i][MAN_PAD-1:0] == '0));

      assert_signed_zero_R6: assert property (@(posedge clk) disable iff (rst)
         (in_data[H_W*i +: H_W-1] == '0) |-> (lane_word[i][S_W-2:0] == '0));

      assert_sub_range_R7: assert property (@(posedge clk) disable iff (rst)
         (in_data[H_W*i + H_MAN_W +: H_EXP_W] == '0 &&
          in_data[H_W*i +: H_MAN_W] != '0)
         |-> (lane_word[i][S_MAN_W +: S_EXP_W] >= S_EXP_W'(SUB_BASE) &&
              lane_word[i][S_MAN_W +: S_EXP_W] <= S_EXP_W'(REBIAS) &&
              lane_cls[i] == CLS_ZERO_SUB));
   end

   hcvt_out_reg #(
      .W (OUT_W)
   ) i_out (
      .clk     (clk),
      .rst     (rst),
      .load    (in_valid),
      .d       (packed_out),
      .valid_q (out_valid),
      .q       (out_data)
   );

   assert_valid_follow_R8: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);

   assert_valid_idle_R8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> !out_valid);

   assert_data_hold_R8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> $stable(out_data));

   assert_reset_clear_R9: assert property (@(posedge clk)
      rst |=> (!out_valid && out_data == '0));

endmodule

// File: tb/test_quad_half_unpack.sv
`timescale 1ns/1ps
module test_quad_half_unpack;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         in_valid = 1'b0;
   logic [63:0]  in_data = '0;
   logic         out_valid;
   logic [127:0] out_data;

   int n_checks = 0;
   int n_bad    = 0;
   bit mon_en   = 1'b0;
   logic [63:0]  sent_q [$];
   logic [127:0] last_exp = '0;

   always #4 clk = ~clk;   // 125 MHz

   quad_half_unpack i_quad_half_unpack (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .in_data   (in_data),
      .out_valid (out_valid),
      .out_data  (out_data)
   );

   // Reference: subnormals normalised by repeated shifting
   function automatic logic [31:0] ref_conv(input logic [15:0] h);
      logic       s;
      logic [4:0] e;
      logic [9:0] m;
      logic [10:0] mm;
      int ex;
      s = h[15]; e = h[14:10]; m = h[9:0];
      if (e == 5'd31) return {s, 8'hFF, m, 13'd0};
      if (e == 5'd0 && m == 10'd0) return {s, 31'd0};
      if (e == 5'd0) begin
         mm = {1'b0, m};
         ex = 113;
         while (!mm[10]) begin
            mm = mm << 1;
            ex = ex - 1;
         end
         return {s, 8'(ex), mm[9:0], 13'd0};
      end
      return {s, 8'(int'(e) + 112), m, 13'd0};
   endfunction

   function automatic string cls_tag(input logic [15:0] h);
      if (h[14:10] == 5'd31) return (h[9:0] == 10'd0) ? "R4" : "R5";
      if (h[14:10] == 5'd0)  return (h[9:0] == 10'd0) ? "R6" : "R7";
      return "R3";
   endfunction

   function automatic logic [127:0] ref_word(input logic [63:0] w);
      logic [127:0] r;
      for (int i = 0; i < 4; i++) r[32*i +: 32] = ref_conv(w[16*i +: 16]);
      return r;
   endfunction

   task automatic check(input bit ok, input string tag,
                        input logic [127:0] act, input logic [127:0] exp);
      n_checks++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // Monitor / scoreboard
   always @(negedge clk) begin
      if (mon_en && !rst) begin
         if (out_valid) begin
            if (sent_q.size() == 0) begin
               check(1'b0, "R8 unexpected out_valid", out_data, last_exp);
            end else begin
               logic [63:0]  w;
               logic [127:0] e;
               w = sent_q.pop_front();
               e = ref_word(w);
               for (int i = 0; i < 4; i++) begin
                  logic [31:0] a32, e32;
                  a32 = out_data[32*i +: 32];
                  e32 = e[32*i +: 32];
                  if (a32[31] != e32[31])
                     check(1'b0, $sformatf("R2 R1 lane %0d", i), 128'(a32), 128'(e32));
                  else
                     check(a32 == e32, $sformatf("%s R1 lane %0d in=%h", cls_tag(w[16*i +: 16]), i, w[16*i +: 16]),
                           128'(a32), 128'(e32));
               end
               last_exp = e;
            end
         end else begin
            check(out_data == last_exp, "R8 hold while idle", out_data, last_exp);
         end
      end
   end

   task automatic send(input logic [63:0] w);
      @(negedge clk);
      in_valid = 1'b1;
      in_data  = w;
      sent_q.push_back(w);
   endtask

   task automatic idle(input int n);
      for (int k = 0; k < n; k++) begin
         @(negedge clk);
         in_valid = 1'b0;
         in_data  = {$urandom, $urandom};
      end
   endtask

   function automatic logic [15:0] rand_half();
      logic [15:0] h;
      h = 16'($urandom);
      case ($urandom % 6)
         0: h[14:10] = 5'd0;
         1: h[14:10] = 5'd31;
         2: begin h[14:0] = '0; end
         3: begin h[14:10] = 5'd31; h[9:0] = '0; end
         default: ;
      endcase
      return h;
   endfunction

   initial begin
      #(8 * 100000);
      n_checks++;
      n_bad++;
      $display("FAIL watchdog expired act=running exp=done");
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      check(out_valid == 1'b0 && out_data == '0, "R9 reset state", out_data, '0);
      rst = 1'b0;
      mon_en = 1'b1;
      idle(2);

      // Directed values, lane 0 lowest (R1): 1.0, smallest subnormal, max normal, -inf
      send({16'hFC00, 16'h7BFF, 16'h0001, 16'h3C00});
      idle(1);
      check(out_data == {32'hFF800000, 32'h477FE000, 32'h33800000, 32'h3F800000},
            "R1 R3 R4 R7 directed", out_data,
            {32'hFF800000, 32'h477FE000, 32'h33800000, 32'h3F800000});
      // NaN payload, -0, largest subnormal, negative normal
      send({16'h7E01, 16'h8000, 16'h03FF, 16'hC000});
      idle(1);
      check(out_data == {32'h7FC02000, 32'h80000000, 32'h387FC000, 32'hC0000000},
            "R2 R5 R6 R7 directed", out_data,
            {32'h7FC02000, 32'h80000000, 32'h387FC000, 32'hC0000000});
      // Each lane alone, others zero (R1 isolation)
      for (int i = 0; i < 4; i++) begin
         logic [63:0] w;
         w = '0;
         w[16*i +: 16] = 16'h0200;
         send(w);
      end
      idle(3);
      // Mixed-class traffic, back-to-back and with gaps
      for (int n = 0; n < 400; n++) begin
         send({rand_half(), rand_half(), rand_half(), rand_half()});
         if ($urandom % 3 == 0) idle(1 + $urandom % 3);
      end
      idle(4);

      // Reset with traffic pending and in_valid held high (R9)
      send(64'h3C00_3C00_3C00_3C00);
      idle(2);
      @(negedge clk);
      mon_en = 1'b0;
      rst = 1'b1;
      in_valid = 1'b1;
      in_data = 64'h4000_4000_4000_4000;
      @(negedge clk);
      check(out_valid == 1'b0 && out_data == '0, "R9 reset with in_valid", out_data, '0);
      @(negedge clk);
      check(out_valid == 1'b0 && out_data == '0, "R9 reset held", out_data, '0);
      in_valid = 1'b0;
      sent_q.delete();
      last_exp = '0;
      @(negedge clk);
      rst = 1'b0;
      mon_en = 1'b1;
      idle(3);
      send(64'h8001_7C00_0000_3555);
      idle(3);

      check(sent_q.size() == 0, "R8 all words returned",
            128'(sent_q.size()), '0);
      $display("  test done: total=%0d bad=%0d", n_checks, n_bad);
      $finish;
   end

endmodule